// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is an N-bit register meant to sit between two clouds of combinational logic and take part in on-chip self test. A two-bit mode selector turns it into one of four things: an ordinary parallel register that captures its data input, a serial scan chain, a multiple-input signature compactor built on a linear feedback shift register, or a synchronous clear.

In signature mode every parallel input bit is XORed into its own stage while the register shifts through its feedback polynomial. Several observation points are therefore folded into one signature on every clock. When the parallel inputs are held at zero, the same mode runs the register as a free-running maximal-length pattern source.

Two instances can be wired in series around a logic cloud. One of them generates patterns and the other compacts the responses. The scan path loads seeds and unloads signatures.

Top module: `selftest_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes all zeros at that edge, whatever the mode and the data inputs.
- R2: With `mode_sel` = 2'b00 (shift), each edge moves stage i-1 into stage i, and `ser_in` enters stage 0. `par_in` has no effect on the result.
- R3: `ser_out` always equals the highest stage, `par_out[N-1]`.
- R4: With `mode_sel` = 2'b01 (signature), stage i for i>0 becomes stage i-1 XOR `par_in[i]`. Stage 0 becomes the feedback XOR `par_in[0]`. The feedback is the XOR of the stages in the tap mask, which for N=8 is stages 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). `ser_in` has no effect.
- R5: In signature mode with `par_in` held at zero and a nonzero start value, the register returns to its start value after exactly 2^N-1 edges and not before.
- R6: With `mode_sel` = 2'b11 (latch), each edge loads `par_in` into the register.
- R7: With `mode_sel` = 2'b10 (clear), the register becomes all zeros at the next edge.
- R8: `par_out` shows the current register content. A change of `mode_sel` or of the data inputs between edges leaves `par_out` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Mode: 00 shift, 01 signature, 10 clear, 11 latch |
| par_in | input | N | Parallel data / observation inputs |
| ser_in | input | 1 | Serial scan input into stage 0 |
| par_out | output | N | Current register content |
| ser_out | output | 1 | Serial scan output from stage N-1 |

## Verification
The whole state is visible on `par_out` at all times. A wrong next-state value in any stage therefore appears at the port one edge after the faulty update, and the bench compares every edge against its own model. In signature mode a single wrong bit spreads through the feedback, so the trajectory keeps diverging rather than healing. The 255-edge period run makes a wrong tap show as a missing or early return to the seed. A mode that wrongly uses an input it should ignore shows up on the very next edge, because the bench drives those inputs with values that differ from the ones that matter.

// File: rtl/strg_pkg.sv
package strg_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_SIG   = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_LATCH = 2'b11
  } mode_e;

  typedef struct packed {
    logic shift;
    logic sig;
    logic clear;
    logic latch;
  } ctl_t;

  // Feedback tap mask for a given width: bit i set means stage i feeds back.
  function automatic logic [63:0] default_taps(input int unsigned width);
    logic [63:0] m;
    m = '0;
    case (width)
      4:  m = 64'h0000_0000_0000_000C;
      5:  m = 64'h0000_0000_0000_0014;
      6:  m = 64'h0000_0000_0000_0030;
      7:  m = 64'h0000_0000_0000_0060;
      8:  m = 64'h0000_0000_0000_00B8;
      16: m = 64'h0000_0000_0000_B400;
      32: m = 64'h0000_0000_8020_0003;
      default: begin
        m[width-1] = 1'b1;
        m[width-2] = 1'b1;
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/strg_decode.sv
module strg_decode
  import strg_pkg::*;
(
  input  logic [1:0] mode_sel,
  output ctl_t       ctl
);
  mode_e m;

  always_comb begin
    m   = mode_e'(mode_sel);
    ctl = '0;
    unique case (m)
      MODE_SHIFT: ctl.shift = 1'b1;
      MODE_SIG:   ctl.sig   = 1'b1;
      MODE_CLEAR: ctl.clear = 1'b1;
      MODE_LATCH: ctl.latch = 1'b1;
      default:    ctl.clear = 1'b1;
    endcase
  end
endmodule

// File: rtl/strg_feedback.sv
module strg_feedback #(
  parameter int unsigned  N    = 8,
  parameter logic [N-1:0] TAPS = 8'hB8
) (
  input  logic [N-1:0] q,
  output logic         fb
);
  logic [N-1:0] chain;

  generate
    for (genvar i = 0; i < N; i++) begin : g_tap
      if (i == 0) begin : g_first
        assign chain[i] = TAPS[i] & q[i];
      end else begin : g_rest
        assign chain[i] = chain[i-1] ^ (TAPS[i] & q[i]);
      end
    end
  endgenerate

  assign fb = chain[N-1];
endmodule

// File: rtl/strg_cell.sv
module strg_cell
  import strg_pkg::*;
(
  input  ctl_t ctl,
  input  logic shift_src,
  input  logic sig_src,
  input  logic par_bit,
  output logic nxt
);
  always_comb begin
    nxt = 1'b0;
    if (ctl.shift)      nxt = shift_src;
    else if (ctl.sig)   nxt = sig_src ^ par_bit;
    else if (ctl.latch) nxt = par_bit;
    else                nxt = 1'b0;
  end
endmodule

// File: rtl/selftest_reg.sv
module selftest_reg
  import strg_pkg::*;
#(
  parameter int unsigned  N        = 8,
  parameter logic [63:0]  TAP_MASK = strg_pkg::default_taps(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_sel,
  input  logic [N-1:0] par_in,
  input  logic         ser_in,
  output logic [N-1:0] par_out,
  output logic         ser_out
);
  localparam logic [N-1:0] TAPS = TAP_MASK[N-1:0];
  localparam int unsigned  MSB  = N - 1;

  ctl_t         ctl;
  logic         fb;
  logic [N-1:0] state_q;
  logic [N-1:0] state_d;

  strg_decode u_dec (
    .mode_sel (mode_sel),
    .ctl      (ctl)
  );

  strg_feedback #(.N(N), .TAPS(TAPS)) u_fb (
    .q  (state_q),
    .fb (fb)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_head
        strg_cell u_cell (
          .ctl       (ctl),
          .shift_src (ser_in),
          .sig_src   (fb),
          .par_bit   (par_in[i]),
          .nxt       (state_d[i])
        );
      end else begin : g_body
        strg_cell u_cell (
          .ctl       (ctl),
          .shift_src (state_q[i-1]),
          .sig_src   (state_q[i-1]),
          .par_bit   (par_in[i]),
          .nxt       (state_d[i])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign par_out = state_q;
  assign ser_out = state_q[MSB];
endmodule

// File: rtl/selftest_reg_chk.sv
module selftest_reg_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode_sel,
  input logic [N-1:0] par_in,
  input logic         ser_in,
  input logic [N-1:0] par_out,
  input logic         ser_out
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (par_out == '0));

  // R2
  shift_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00) |=> (par_out == {$past(par_out[N-2:0]), $past(ser_in)}));

  // R3
  serial_tail_chk: assert property (@(posedge clk) disable iff (rst)
    ser_out == par_out[N-1]);

  // R4
  sig_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01) |=> (par_out[N-1:1] == ($past(par_out[N-2:0]) ^ $past(par_in[N-1:1]))));

  // R6
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |=> (par_out == $past(par_in)));

  // R7
  clear_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10) |=> (par_out == '0));
endmodule

bind selftest_reg selftest_reg_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .par_in   (par_in),
  .ser_in   (ser_in),
  .par_out  (par_out),
  .ser_out  (ser_out)
);

// File: tb/tb_selftest_reg.sv
module tb_selftest_reg;
  localparam int N = 8;
  localparam logic [N-1:0] TAPS = 8'hB8;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_sel = 2'b11;
  logic [N-1:0] par_in = '0;
  logic         ser_in = 1'b0;
  logic [N-1:0] par_out;
  logic         ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [N-1:0] model = '0;
  item_t sbq[$];

  selftest_reg #(.N(N)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .par_in(par_in),
    .ser_in(ser_in), .par_out(par_out), .ser_out(ser_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] nxt(input logic r, input logic [1:0] m,
                                       input logic [N-1:0] s, input logic [N-1:0] p,
                                       input logic si);
    if (r) return '0;
    case (m)
      2'b00: return {s[N-2:0], si};
      2'b01: return {s[N-2:0], ^(s & TAPS)} ^ p;
      2'b10: return '0;
      default: return p;
    endcase
  endfunction

  // Driver: drive at falling edge, check R8 mid-cycle, push expected item.
  task automatic step(input logic r, input logic [1:0] m, input logic [N-1:0] p,
                      input logic si, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; mode_sel = m; par_in = p; ser_in = si;
    #1;
    chk(par_out == model, "R8", par_out, model);
    model = nxt(r, m, model, p, si);
    it.exp = model;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: pop and compare shortly after each rising edge.
  always @(posedge clk) begin
    item_t it;
    #2;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      chk(par_out == it.exp, it.tag, par_out, it.exp);
      chk(ser_out == it.exp[N-1], "R3", {7'b0, ser_out}, {7'b0, it.exp[N-1]});
    end
  end

  initial begin
    logic [N-1:0] seed;
    bit early;
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 2'b11, 8'hFF, 1'b1, "R1");
    // R6: latch
    step(1'b0, 2'b11, 8'hA5, 1'b1, "R6");
    step(1'b0, 2'b11, 8'h3C, 1'b0, "R6");
    // R2: shift with par_in junk (ignored)
    for (int i = 0; i < 10; i++) step(1'b0, 2'b00, 8'hFF ^ 8'(i), 1'(i % 3 == 0), "R2");
    // R7: clear from nonzero
    step(1'b0, 2'b11, 8'h81, 1'b0, "R6");
    step(1'b0, 2'b10, 8'hFF, 1'b1, "R7");
    // R4: signature with varying inputs, ser_in toggling (ignored)
    step(1'b0, 2'b11, 8'h5A, 1'b0, "R6");
    for (int i = 0; i < 20; i++) step(1'b0, 2'b01, 8'(i * 37 + 11), 1'(i & 1), "R4");
    // R5: period of pattern source
    seed = 8'h01;
    step(1'b0, 2'b11, seed, 1'b0, "R6");
    early = 1'b0;
    for (int i = 1; i <= 255; i++) begin
      step(1'b0, 2'b01, 8'h00, 1'b0, "R5");
      if (i < 255 && model == seed) early = 1'b1;
    end
    @(posedge clk); #3;
    chk(!early, "R5", {7'b0, early}, 8'h00);
    chk(par_out == seed, "R5", par_out, seed);
    // R1: reset wins over latch
    step(1'b0, 2'b11, 8'hC3, 1'b0, "R6");
    step(1'b1, 2'b11, 8'hFF, 1'b1, "R1");
    step(1'b0, 2'b01, 8'h00, 1'b0, "R4");
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule